// File: doc/BRIEF.md
# Watchpoint address register bank

This block holds the address values of a set of debug watchpoints, one 32-bit register per watchpoint. The block is built with between 1 and 16 watchpoints. A coprocessor-style access port reaches the registers. Each request carries a 4-bit register index, a read/write direction, write data, the current privilege level (0 to 3) and a set of trap and halt control bits. Before any register is touched, the request passes a fixed-priority permission decision.

The decision is made combinationally in the same cycle as the request. It gives exactly one outcome: undefined, trap to level 2, trap to level 3, debug halt, or a completed access. A trap also reports syndrome class 0x05. A completed write stores the address bits [31:2] at the next clock edge. A completed read returns the stored address with the two low bits forced to zero. Any other outcome leaves the storage as it was.

Top module: `wpt_addr_bank`

## Requirements
- R1: An access whose index is not below NUM_WP gives result code 2 (undefined) at every privilege level, and such a write changes no implemented register.
- R2: Any access at privilege level 0 gives result code 2 (undefined).
- R3: At level 1 or 2, when the undefined-priority flag and the level-3 trap bit are both set, the result is code 2. This check comes before all the other trap checks.
- R4: At level 1 only, when level 2 is enabled and either the host-trap bit or the access-trap bit of level 2 is set, the result is code 3 (trap to level 2). At level 2 these bits have no effect.
- R5: At level 1 or 2, when no earlier step fires and the level-3 trap bit is set, the result is code 4 (trap to level 3). If the level-3 undefine flag is also set, the result is code 2 instead.
- R6: At level 3, none of the trap bits or undefine flags has any effect. Only the halt check applies.
- R7: When no earlier step fires, the result is code 5 (debug halt) if the OS lock is clear, halting is allowed and the external trap-to-halt bit is set. Otherwise the result is code 1 (completed).
- R8: A completed write stores wdata[31:2] in the indexed slot at the next rising clock edge. A completed read returns the stored bits with bits [1:0] equal to zero. A value with bit 2 set is stored as written.
- R9: A write whose result is not code 1 leaves every stored value unchanged.
- R10: Reset clears every slot to zero. While no access is requested, the result is code 0 (none).
- R11: rd_data is zero unless the result is code 1 for a read. trap_class is 0x05 for result codes 3 and 4, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| l2_enabled | input | 1 | Level 2 is enabled |
| l2_trap_host | input | 1 | Level-2 host-trap bit |
| l2_trap_acc | input | 1 | Level-2 access-trap bit |
| l3_trap | input | 1 | Level-3 trap bit |
| l3_undef_prio | input | 1 | Level-3 trap becomes undefined before the level-2 check |
| l3_undef | input | 1 | Level-3 trap becomes undefined after the level-2 check |
| os_lock | input | 1 | OS lock is set |
| halt_ok | input | 1 | Halting is allowed |
| ext_halt | input | 1 | External trap-to-halt bit |
| result | output | 3 | 0 none, 1 completed, 2 undefined, 3 trap L2, 4 trap L3, 5 halt |
| trap_class | output | 6 | Syndrome class for traps |
| rd_data | output | 32 | Read data for a completed read |

## Verification
The bench targets the ordering corners of the decision:
- The undefined-priority flag against a pending level-2 trap. A design that checked level 2 first would report a trap to level 2 where undefined is required.
- The level-2 bits at level 2 and all the trap bits at level 3. A design that did not skip these steps would trap where the access must complete.
- An out-of-range index at level 3. A design with a weak range check would complete the access, or write into a real slot.
- Blocked writes, read back through the port. A design that used the enable before the decision would corrupt the stored address.
- Writes of all ones and of bit 2 alone. A design that got the address slice wrong would show the two low bits, or drop bit 2.

// File: rtl/wpt_addr_bank.sv
module wpt_addr_bank #(
  parameter int NUM_WP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [3:0]  acc_idx,
  input  logic [31:0] acc_wdata,
  input  logic [1:0]  priv_lvl,
  input  logic        l2_enabled,
  input  logic        l2_trap_host,
  input  logic        l2_trap_acc,
  input  logic        l3_trap,
  input  logic        l3_undef_prio,
  input  logic        l3_undef,
  input  logic        os_lock,
  input  logic        halt_ok,
  input  logic        ext_halt,
  output logic [2:0]  result,
  output logic [5:0]  trap_class,
  output logic [31:0] rd_data
);
  localparam logic [2:0] RES_NONE  = 3'd0;
  localparam logic [2:0] RES_OK    = 3'd1;
  localparam logic [2:0] RES_UNDEF = 3'd2;
  localparam logic [2:0] RES_TRAP2 = 3'd3;
  localparam logic [2:0] RES_TRAP3 = 3'd4;
  localparam logic [2:0] RES_HALT  = 3'd5;
  localparam logic [5:0] SYN_CLASS = 6'h05;
  localparam int         AW        = 30;

  logic [NUM_WP-1:0][AW-1:0] mem;
  logic [AW-1:0]             rd_sel;
  logic                      idx_ok;
  logic [2:0]                tail_res;
  logic                      commit_wr;

  assign idx_ok   = int'(acc_idx) < NUM_WP;
  assign tail_res = (!os_lock && halt_ok && ext_halt) ? RES_HALT : RES_OK;

  always_comb begin
    result = RES_NONE;
    if (acc_valid) begin
      if (!idx_ok) begin
        result = RES_UNDEF;
      end else begin
        case (priv_lvl)
          2'd0: result = RES_UNDEF;
          2'd1: begin
            if (l3_undef_prio && l3_trap)                      result = RES_UNDEF;
            else if (l2_enabled && (l2_trap_host || l2_trap_acc)) result = RES_TRAP2;
            else if (l3_trap)                                  result = l3_undef ? RES_UNDEF : RES_TRAP3;
            else                                               result = tail_res;
          end
          2'd2: begin
            if (l3_undef_prio && l3_trap) result = RES_UNDEF;
            else if (l3_trap)             result = l3_undef ? RES_UNDEF : RES_TRAP3;
            else                          result = tail_res;
          end
          default: result = tail_res;
        endcase
      end
    end
  end

  assign trap_class = (result == RES_TRAP2 || result == RES_TRAP3) ? SYN_CLASS : 6'h00;
  assign commit_wr  = acc_write && (result == RES_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (commit_wr) begin
      for (int i = 0; i < NUM_WP; i++)
        if (int'(acc_idx) == i) mem[i] <= acc_wdata[31:2];
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_WP; i++)
      if (int'(acc_idx) == i) rd_sel = mem[i];
  end

  assign rd_data = (result == RES_OK && !acc_write) ? {rd_sel, 2'b00} : 32'h0;

  assert_l0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && priv_lvl == 2'd0) |-> result == RES_UNDEF);

  assert_range_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && int'(acc_idx) >= NUM_WP) |-> result == RES_UNDEF);

  assert_l3_no_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && idx_ok && priv_lvl == 2'd3) |-> (result == RES_OK || result == RES_HALT));

  assert_prio_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && idx_ok && priv_lvl != 2'd3 && l3_undef_prio && l3_trap) |-> result == RES_UNDEF);

  assert_blocked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && result != RES_OK) |=> $stable(mem));

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && result == RES_OK) |=>
      (!(acc_valid && !acc_write && result == RES_OK && acc_idx == $past(acc_idx))
       || rd_data == {$past(acc_wdata[31:2]), 2'b00}));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (result == RES_NONE && rd_data == 32'h0));
endmodule

// File: tb/tb_wpt_addr_bank.sv
module tb_wpt_addr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NWP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_idx = '0;
  logic [31:0] acc_wdata = '0;
  logic [1:0]  priv_lvl = '0;
  logic        l2_enabled = 0, l2_trap_host = 0, l2_trap_acc = 0;
  logic        l3_trap = 0, l3_undef_prio = 0, l3_undef = 0;
  logic        os_lock = 0, halt_ok = 0, ext_halt = 0;
  logic [2:0]  result;
  logic [5:0]  trap_class;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpt_addr_bank #(.NUM_WP(NWP)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .priv_lvl(priv_lvl),
    .l2_enabled(l2_enabled), .l2_trap_host(l2_trap_host), .l2_trap_acc(l2_trap_acc),
    .l3_trap(l3_trap), .l3_undef_prio(l3_undef_prio), .l3_undef(l3_undef),
    .os_lock(os_lock), .halt_ok(halt_ok), .ext_halt(ext_halt),
    .result(result), .trap_class(trap_class), .rd_data(rd_data));

  // row: {priv[1:0], idx[3:0], ctl[8:0], expected result[2:0]}
  // ctl: [8] l2_enabled [7] l2_trap_host [6] l2_trap_acc [5] l3_trap [4] l3_undef_prio
  //      [3] l3_undef [2] os_lock [1] halt_ok [0] ext_halt
  localparam int NV = 19;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 4'd0,  9'h000, 3'd1},  // R7 plain completion
    {2'd0, 4'd0,  9'h000, 3'd2},  // R2
    {2'd1, 4'd4,  9'h000, 3'd2},  // R1
    {2'd3, 4'd15, 9'h000, 3'd2},  // R1 at level 3
    {2'd1, 4'd1,  9'h170, 3'd2},  // R3 beats level-2 trap
    {2'd1, 4'd2,  9'h180, 3'd3},  // R4 host bit
    {2'd1, 4'd3,  9'h160, 3'd3},  // R4 beats level-3 trap
    {2'd1, 4'd0,  9'h080, 3'd1},  // R4 needs level 2 enabled
    {2'd1, 4'd1,  9'h020, 3'd4},  // R5
    {2'd1, 4'd2,  9'h028, 3'd2},  // R5 undefine flag
    {2'd2, 4'd3,  9'h180, 3'd1},  // R4 skipped at level 2
    {2'd2, 4'd0,  9'h160, 3'd4},  // R5 at level 2
    {2'd2, 4'd1,  9'h030, 3'd2},  // R3 at level 2
    {2'd3, 4'd2,  9'h1B0, 3'd1},  // R6
    {2'd3, 4'd3,  9'h003, 3'd5},  // R6 halt applies
    {2'd3, 4'd0,  9'h007, 3'd1},  // R7 os lock blocks halt
    {2'd1, 4'd1,  9'h002, 3'd1},  // R7 needs ext bit
    {2'd1, 4'd2,  9'h023, 3'd4},  // R5 beats halt
    {2'd2, 4'd3,  9'h003, 3'd5}   // R7 at level 2
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] pl, input logic [3:0] idx, input logic [8:0] ctl,
                       input logic wr, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_idx = idx; acc_wdata = wd; priv_lvl = pl;
    {l2_enabled, l2_trap_host, l2_trap_acc, l3_trap, l3_undef_prio, l3_undef,
     os_lock, halt_ok, ext_halt} = ctl;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    #1;
  endtask

  task automatic read_expect(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    drive(2'd1, idx, 9'h000, 1'b0, 32'h0);
    chk(result == 3'd1 && rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(result == 3'd0 && rd_data == 0, "R10 idle", {29'd0, result}, 0);
    for (int i = 0; i < NWP; i++) read_expect(i[3:0], 32'h0, "R10 reset value");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:16], VEC[i][15:12], VEC[i][11:3], 1'b0, 32'h0);
      chk(result == VEC[i][2:0], $sformatf("R1-7 row %0d result", i), {29'd0, result}, {29'd0, VEC[i][2:0]});
      chk(trap_class == ((VEC[i][2:0] == 3'd3 || VEC[i][2:0] == 3'd4) ? 6'h05 : 6'h00),
          "R11 trap class", {26'd0, trap_class}, 32'h5);
      if (VEC[i][2:0] != 3'd1) chk(rd_data == 0, "R11 no data", rd_data, 0);
    end

    drive(2'd1, 4'd1, 9'h000, 1'b1, 32'hFFFF_FFFF);
    chk(result == 3'd1 && rd_data == 0, "R11 write gives no data", rd_data, 0);
    drive(2'd3, 4'd2, 9'h000, 1'b1, 32'h0000_0004);
    read_expect(4'd1, 32'hFFFF_FFFC, "R8 low bits zero");
    read_expect(4'd2, 32'h0000_0004, "R8 bit2 accepted");

    drive(2'd1, 4'd1, 9'h020, 1'b1, 32'h1234_5678);  // R9 trapped
    drive(2'd2, 4'd1, 9'h003, 1'b1, 32'h1234_5678);  // R9 halted
    drive(2'd0, 4'd2, 9'h000, 1'b1, 32'h1234_5678);  // R9 undefined
    drive(2'd1, 4'd3, 9'h180, 1'b1, 32'h1234_5678);  // R9 trap level 2
    read_expect(4'd1, 32'hFFFF_FFFC, "R9 slot1 kept");
    read_expect(4'd2, 32'h0000_0004, "R9 slot2 kept");
    read_expect(4'd3, 32'h0, "R9 slot3 kept");

    drive(2'd3, 4'd4, 9'h000, 1'b1, 32'hAAAA_AAAA);
    chk(result == 3'd2, "R1 out of range write", {29'd0, result}, 2);
    drive(2'd3, 4'd15, 9'h000, 1'b1, 32'hAAAA_AAAA);
    read_expect(4'd0, 32'h0, "R1 slot0 untouched");
    read_expect(4'd1, 32'hFFFF_FFFC, "R1 slot1 untouched");
    read_expect(4'd3, 32'h0, "R1 slot3 untouched");

    drive(2'd1, 4'd1, 9'h020, 1'b0, 32'h0);
    chk(rd_data == 0 && trap_class == 6'h05, "R11 trapped read", rd_data, 0);

    idle();
    chk(result == 3'd0, "R10 no request", {29'd0, result}, 0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    read_expect(4'd1, 32'h0, "R10 reset clears");

    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule